// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

This block is a general-purpose I/O port of `WIDTH` pins (eight by default) behind a small register bus made of a write strobe, an address, write data and read data. Each pin has its own direction, output value, pull enable, two function-select bits, interrupt enable and edge polarity. The port samples the pins through a synchronizer chain. On each pin it watches for the rising or falling edge chosen by that pin's polarity bit, and latches a sticky flag when it sees it. A single interrupt request combines every enabled flag of a pin in GPIO mode. This request is gated by a global enable input.

The pad side carries the output enable, the output value and the pull controls. The output value comes from a per-pin function mux. That mux picks the port's own output register, a primary peripheral value or a secondary peripheral value. Pads and analog behaviour lie outside the block. A change of the pin level caused by a write to the output or direction register comes back through the pad and the synchronizer. It is then flagged like any external edge.

Register addresses: 0 pin level (read-only), 1 output value, 2 direction, 3 pull enable, 4 function-select high bit, 5 function-select low bit, 6 interrupt enable, 7 edge polarity, 8 flags. Other addresses read as zero.

Top module: `gpio_edge_port`

## Requirements
- R1: Bit i of `pad_oe` equals bit i of the direction register (1 = output, 0 = input).
- R2: Address 0 returns the pin level two clock edges after it is applied at `pin_in`. Writes to address 0 change no register.
- R3: The output register (address 1) reads back the last value written to it.
- R4: `pad_pull_en` bit i is pull-enable bit i AND the pin is an input. `pad_pull_up` bit i equals output-register bit i (1 = pull-up, 0 = pull-down).
- R5: The function code of a pin is {select-high bit, select-low bit}. For code 00, `pad_out` is the output register. For 01 it is `pri_out`, for 11 it is `sec_out`, and for the reserved code 10 it is 0.
- R6: With polarity bit 0, a low-to-high transition of the synchronized pin sets the flag. With polarity bit 1, a high-to-low transition sets it. The flag is readable three edges after the pin change.
- R7: Flags stay set until software writes them. A write to address 8 loads the written value, so a 1 sets a flag and a 0 clears it. A hardware edge in the same cycle as a clearing write leaves the flag set.
- R8: `irq` is high exactly when `gie` is high and some pin in GPIO mode has both its flag and its enable set.
- R9: A pin whose function code is not 00 gets no hardware flag set. Its flag does not drive `irq`, even when software has set it.
- R10: A write to the output or direction register that changes the level seen on an input-looped pin sets that pin's flag through the normal edge path.
- R11: After reset every register, every flag, `pad_oe` and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for `bus_addr` (combinational) |
| pin_in | input | WIDTH | Pin levels from the pads |
| pri_out | input | WIDTH | Primary peripheral output values |
| sec_out | input | WIDTH | Secondary peripheral output values |
| gie | input | 1 | Global interrupt enable |
| pad_oe | output | WIDTH | Pad output enable |
| pad_out | output | WIDTH | Pad output value |
| pad_pull_en | output | WIDTH | Pad pull resistor enable |
| pad_pull_up | output | WIDTH | Pull direction (1 up, 0 down) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the port with its defaults, `WIDTH` = 8 and `SYNC_STAGES` = 2. With these values the two-edge read latency and the three-edge flag latency are fixed, and the bench times its samples against them. Fixing the latency also makes it possible to land a clearing write in the exact cycle where a detected edge is pending. With eight pins, one stimulus can carry every function code and both polarities side by side. A modelled pad loops `pad_out` back onto the pin whenever `pad_oe` is set, which makes register-driven edges observable.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int unsigned REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    RA_PIN   = 4'd0,
    RA_DRV   = 4'd1,
    RA_DIR   = 4'd2,
    RA_PULL  = 4'd3,
    RA_FSELH = 4'd4,
    RA_FSELL = 4'd5,
    RA_IEN   = 4'd6,
    RA_POL   = 4'd7,
    RA_FLAG  = 4'd8
  } reg_addr_e;

  typedef enum logic [1:0] {
    FN_GPIO = 2'b00,
    FN_PRI  = 2'b01,
    FN_RSVD = 2'b10,
    FN_SEC  = 2'b11
  } pin_fn_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][WIDTH-1:0] stage_q;
  logic [SYNC_STAGES-1:0][WIDTH-1:0] stage_nxt;

  always_comb begin
    stage_nxt[0] = async_in;
    for (int s = 1; s < SYNC_STAGES; s++) begin
      stage_nxt[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_nxt;
    end
  end

  assign sync_out = stage_q[LAST];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_edge_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [WIDTH-1:0]  sample,
  input  logic [WIDTH-1:0]  flag_q,
  output logic [WIDTH-1:0]  drv_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  pull_q,
  output logic [WIDTH-1:0]  fsh_q,
  output logic [WIDTH-1:0]  fsl_q,
  output logic [WIDTH-1:0]  ien_q,
  output logic [WIDTH-1:0]  pol_q,
  output logic              flag_we,
  output logic [WIDTH-1:0]  rd_data
);

  logic drv_we, dir_we, pull_we, fsh_we, fsl_we, ien_we, pol_we;

  always_comb begin
    drv_we  = 1'b0;
    dir_we  = 1'b0;
    pull_we = 1'b0;
    fsh_we  = 1'b0;
    fsl_we  = 1'b0;
    ien_we  = 1'b0;
    pol_we  = 1'b0;
    flag_we = 1'b0;
    if (wr_en) begin
      case (reg_addr_e'(addr))
        RA_DRV:   drv_we  = 1'b1;
        RA_DIR:   dir_we  = 1'b1;
        RA_PULL:  pull_we = 1'b1;
        RA_FSELH: fsh_we  = 1'b1;
        RA_FSELL: fsl_we  = 1'b1;
        RA_IEN:   ien_we  = 1'b1;
        RA_POL:   pol_we  = 1'b1;
        RA_FLAG:  flag_we = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q  <= '0;
      dir_q  <= '0;
      pull_q <= '0;
      fsh_q  <= '0;
      fsl_q  <= '0;
      ien_q  <= '0;
      pol_q  <= '0;
    end else begin
      if (drv_we)  drv_q  <= wr_data;
      if (dir_we)  dir_q  <= wr_data;
      if (pull_we) pull_q <= wr_data;
      if (fsh_we)  fsh_q  <= wr_data;
      if (fsl_we)  fsl_q  <= wr_data;
      if (ien_we)  ien_q  <= wr_data;
      if (pol_we)  pol_q  <= wr_data;
    end
  end

  always_comb begin
    case (reg_addr_e'(addr))
      RA_PIN:   rd_data = sample;
      RA_DRV:   rd_data = drv_q;
      RA_DIR:   rd_data = dir_q;
      RA_PULL:  rd_data = pull_q;
      RA_FSELH: rd_data = fsh_q;
      RA_FSELL: rd_data = fsl_q;
      RA_IEN:   rd_data = ien_q;
      RA_POL:   rd_data = pol_q;
      RA_FLAG:  rd_data = flag_q;
      default:  rd_data = '0;
    endcase
  end

  AST_DRV_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_AW'(RA_DRV)) |=> (drv_q == $past(wr_data))); // R3

  AST_PIN_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_AW'(RA_PIN)) |=>
      $stable({drv_q, dir_q, pull_q, fsh_q, fsl_q, ien_q, pol_q})); // R2

endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sample,
  input  logic [WIDTH-1:0] pol,
  input  logic [WIDTH-1:0] gpio_mask,
  input  logic             flag_we,
  input  logic [WIDTH-1:0] flag_wdata,
  output logic [WIDTH-1:0] flag_q
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] rise, fall, hw_hit;
  logic [WIDTH-1:0] flag_nxt;

  always_comb begin
    rise   = sample & ~prev_q;
    fall   = ~sample & prev_q;
    hw_hit = ((rise & ~pol) | (fall & pol)) & gpio_mask;
    if (flag_we) begin
      flag_nxt = flag_wdata | hw_hit;
    end else begin
      flag_nxt = flag_q | hw_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= sample;
      flag_q <= flag_nxt;
    end
  end

  AST_RISE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sample & ~prev_q & ~pol & gpio_mask)) |=>
      ((flag_q & $past(sample & ~prev_q & ~pol & gpio_mask)) ==
       $past(sample & ~prev_q & ~pol & gpio_mask))); // R6

  AST_FALL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~sample & prev_q & pol & gpio_mask)) |=>
      ((flag_q & $past(~sample & prev_q & pol & gpio_mask)) ==
       $past(~sample & prev_q & pol & gpio_mask))); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R7

  AST_PERIPH_NO_HW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> ((flag_q & ~$past(flag_q) & ~$past(gpio_mask)) == '0)); // R9

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_edge_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] drv,
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] pull,
  input  logic [WIDTH-1:0] fsh,
  input  logic [WIDTH-1:0] fsl,
  input  logic [WIDTH-1:0] pri_out,
  input  logic [WIDTH-1:0] sec_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pull_en,
  output logic [WIDTH-1:0] pad_pull_up,
  output logic [WIDTH-1:0] gpio_mask
);

  assign pad_oe      = dir;
  assign pad_pull_en = pull & ~dir;
  assign pad_pull_up = drv;

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    pin_fn_e fn;
    logic    bit_out;

    always_comb begin
      fn = pin_fn_e'({fsh[g], fsl[g]});
      case (fn)
        FN_GPIO: bit_out = drv[g];
        FN_PRI:  bit_out = pri_out[g];
        FN_SEC:  bit_out = sec_out[g];
        default: bit_out = 1'b0;
      endcase
    end

    assign pad_out[g]   = bit_out;
    assign gpio_mask[g] = (fn == FN_GPIO);
  end

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  input  logic [WIDTH-1:0]  pri_out,
  input  logic [WIDTH-1:0]  sec_out,
  input  logic              gie,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_pull_en,
  output logic [WIDTH-1:0]  pad_pull_up,
  output logic              irq
);

  logic [WIDTH-1:0] sample;
  logic [WIDTH-1:0] drv_q, dir_q, pull_q, fsh_q, fsl_q, ien_q, pol_q;
  logic [WIDTH-1:0] flag_q, gpio_mask;
  logic             flag_we;

  gpio_sync #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (sample)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr_en),
    .addr    (bus_addr),
    .wr_data (bus_wdata),
    .sample  (sample),
    .flag_q  (flag_q),
    .drv_q   (drv_q),
    .dir_q   (dir_q),
    .pull_q  (pull_q),
    .fsh_q   (fsh_q),
    .fsl_q   (fsl_q),
    .ien_q   (ien_q),
    .pol_q   (pol_q),
    .flag_we (flag_we),
    .rd_data (bus_rdata)
  );

  gpio_pad_mux #(.WIDTH(WIDTH)) u_mux (
    .drv         (drv_q),
    .dir         (dir_q),
    .pull        (pull_q),
    .fsh         (fsh_q),
    .fsl         (fsl_q),
    .pri_out     (pri_out),
    .sec_out     (sec_out),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .pad_pull_en (pad_pull_en),
    .pad_pull_up (pad_pull_up),
    .gpio_mask   (gpio_mask)
  );

  gpio_edge_flags #(.WIDTH(WIDTH)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample     (sample),
    .pol        (pol_q),
    .gpio_mask  (gpio_mask),
    .flag_we    (flag_we),
    .flag_wdata (bus_wdata),
    .flag_q     (flag_q)
  );

  assign irq = gie & (|(flag_q & ien_q & gpio_mask));

endmodule

// File: tb/gpio_edge_port_tb.sv
module gpio_edge_port_tb_top;

  localparam int unsigned W      = 8;
  localparam time         CLK_PD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_wr_en;
  logic [3:0]   bus_addr;
  logic [W-1:0] bus_wdata, bus_rdata;
  logic [W-1:0] ext_val, pin_in, pri_out, sec_out;
  logic         gie;
  logic [W-1:0] pad_oe, pad_out, pad_pull_en, pad_pull_up;
  logic         irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PD/2) clk = ~clk;

  // pad model: driven pins loop back, others follow the outside world
  assign pin_in = (pad_oe & pad_out) | (~pad_oe & ext_val);

  gpio_edge_port #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
    .clk (clk), .rst_n (rst_n), .bus_wr_en (bus_wr_en), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .pin_in (pin_in),
    .pri_out (pri_out), .sec_out (sec_out), .gie (gie), .pad_oe (pad_oe),
    .pad_out (pad_out), .pad_pull_en (pad_pull_en), .pad_pull_up (pad_pull_up),
    .irq (irq)
  );

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_wr_en = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic t_reset;
    logic [W-1:0] d;
    for (int a = 1; a <= 8; a++) begin
      bus_rd(4'(a), d);
      check("R11 reg reset", d, '0);
    end
    check("R11 pad_oe reset", pad_oe, '0);
    check("R11 irq reset", {7'b0, irq}, '0);
  endtask

  task automatic t_pin_level;
    logic [W-1:0] d;
    @(negedge clk); ext_val = 8'hA5;
    idle(2);
    bus_rd(4'd0, d);
    check("R2 pin level", d, 8'hA5);
    bus_wr(4'd0, 8'hFF);
    bus_rd(4'd0, d);
    check("R2 pin write ignored", d, 8'hA5);
    bus_rd(4'd1, d);
    check("R2 write left output reg", d, 8'h00);
    @(negedge clk); ext_val = 8'h00;
    idle(4);
  endtask

  task automatic t_drive_dir;
    logic [W-1:0] d;
    bus_wr(4'd1, 8'h3C);
    bus_rd(4'd1, d);
    check("R3 output readback", d, 8'h3C);
    bus_wr(4'd2, 8'hF0);
    @(negedge clk); #1;
    check("R1 pad_oe", pad_oe, 8'hF0);
    check("R5 gpio pad_out", pad_out, 8'h3C);
    bus_wr(4'd3, 8'hFF);
    @(negedge clk); #1;
    check("R4 pull enable", pad_pull_en, 8'h0F);
    check("R4 pull direction", pad_pull_up, 8'h3C);
    bus_wr(4'd3, 8'h00);
    bus_wr(4'd2, 8'h00);
    bus_wr(4'd1, 8'h00);
    idle(4);
    bus_wr(4'd8, 8'h00);
  endtask

  task automatic t_fsel;
    pri_out = 8'hFF; sec_out = 8'hFF;
    bus_wr(4'd4, 8'h3C);
    bus_wr(4'd5, 8'h33);
    @(negedge clk); #1;
    check("R5 peripheral mux", pad_out, 8'h33);
    bus_wr(4'd1, 8'hFF);
    @(negedge clk); #1;
    check("R5 mux with gpio and reserved", pad_out, 8'hF3);
    pri_out = 8'h00;
    #1 check("R5 primary follows input", pad_out, 8'hF0);
    bus_wr(4'd4, 8'h00);
    bus_wr(4'd5, 8'h00);
    bus_wr(4'd1, 8'h00);
  endtask

  task automatic t_polarity;
    logic [W-1:0] d;
    bus_wr(4'd8, 8'h00);
    bus_wr(4'd7, 8'hF0);
    @(negedge clk); ext_val = 8'hFF;
    idle(4);
    bus_rd(4'd8, d);
    check("R6 rising edges", d, 8'h0F);
    @(negedge clk); ext_val = 8'h00;
    idle(4);
    bus_rd(4'd8, d);
    check("R6 falling edges", d, 8'hFF);
    bus_wr(4'd7, 8'h00);
  endtask

  task automatic t_sticky;
    logic [W-1:0] d;
    bus_wr(4'd8, 8'h00);
    bus_rd(4'd8, d);
    check("R7 software clear", d, 8'h00);
    bus_wr(4'd8, 8'h81);
    idle(5);
    bus_rd(4'd8, d);
    check("R7 software set sticks", d, 8'h81);
  endtask

  task automatic t_irq;
    bus_wr(4'd6, 8'h00);
    gie = 1'b1;
    @(negedge clk); #1;
    check("R8 no enable no irq", {7'b0, irq}, 8'h00);
    bus_wr(4'd6, 8'h01);
    gie = 1'b0;
    #1 check("R8 gie low blocks irq", {7'b0, irq}, 8'h00);
    gie = 1'b1;
    #1 check("R8 irq raised", {7'b0, irq}, 8'h01);
    bus_wr(4'd6, 8'h02);
    #1 check("R8 unflagged enable no irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_periph;
    logic [W-1:0] d;
    bus_wr(4'd6, 8'h01);
    bus_wr(4'd5, 8'h01);
    #1 check("R9 peripheral pin masks irq", {7'b0, irq}, 8'h00);
    bus_wr(4'd8, 8'h00);
    @(negedge clk); ext_val = 8'h01;
    idle(4);
    bus_rd(4'd8, d);
    check("R9 no hardware flag", d, 8'h00);
    bus_wr(4'd5, 8'h00);
    bus_wr(4'd6, 8'h00);
    @(negedge clk); ext_val = 8'h00;
    idle(4);
    bus_wr(4'd8, 8'h00);
  endtask

  task automatic t_loopback;
    logic [W-1:0] d;
    bus_wr(4'd2, 8'h01);
    idle(4);
    bus_wr(4'd8, 8'h00);
    bus_wr(4'd1, 8'h01);
    idle(4);
    bus_rd(4'd8, d);
    check("R10 output write sets flag", d, 8'h01);
    bus_wr(4'd7, 8'h01);
    bus_wr(4'd8, 8'h00);
    bus_wr(4'd2, 8'h00);
    idle(4);
    bus_rd(4'd8, d);
    check("R10 direction write sets flag", d, 8'h01);
    bus_wr(4'd7, 8'h00);
    bus_wr(4'd1, 8'h00);
    bus_wr(4'd8, 8'h00);
  endtask

  task automatic t_collision;
    logic [W-1:0] d;
    @(negedge clk); ext_val = 8'h02;
    @(posedge clk);
    @(posedge clk);
    bus_wr(4'd8, 8'h00);
    bus_rd(4'd8, d);
    check("R7 hardware set wins over clear", d, 8'h02);
    bus_wr(4'd8, 8'h00);
    bus_rd(4'd8, d);
    check("R7 later clear takes effect", d, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    ext_val = '0; pri_out = '0; sec_out = '0; gie = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_pin_level();
    t_drive_dir();
    t_fsel();
    t_polarity();
    t_sticky();
    t_irq();
    t_periph();
    t_loopback();
    t_collision();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired got=%h exp=%h", 1'b0, 1'b1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule